// File: doc/BRIEF.md
# Snooping Three-State Cache Controller

This block keeps one processor's small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each of the cache lines has a tag, one data word and a coherence state: invalid, shared (read-only) or exclusive (writable and dirty). The processor sees a plain valid/ready request port. Hits are served with no bus traffic. A miss holds the processor while the controller asks an external arbiter for the bus, writes back a dirty line that has to leave, and then issues a read or write miss.

Every transaction other caches put on the bus is presented to the snoop inputs. A remote read of a block this cache holds exclusive makes the controller flush the dirty word in the same cycle and keep a shared copy. A remote write miss invalidates the copy, and flushes it first if it was dirty. Snoops always take effect before any pending request of the local processor. That request is then judged again against the line's new state once the grant arrives.

Top module: `snoop_cache_ctl`

## Requirements
- R1: After reset every line is invalid, `bus_req`, `cpu_ready` and `flush_valid` are low and `bus_cmd` is 0 (none), so the first read of any address misses.
- R2: A read that misses drives `bus_cmd`=1 (read miss) with the request address. It completes in the cycle `fill_valid` is high, returning `fill_data`, and leaves the line shared.
- R3: A read to a line whose tag matches and whose state is shared or exclusive completes with the stored word and puts no command on the bus.
- R4: A write to an invalid or shared line drives `bus_cmd`=2 (write miss) with the address and write data. The write completes in that cycle and leaves the line exclusive with the new word.
- R5: A write to a line held exclusive completes with no bus command and updates the stored word.
- R6: A snooped read miss (`snp_cmd`=1) from another requester to a block held exclusive raises `flush_valid` in the same cycle with the stored word on `flush_data`, and the line becomes shared.
- R7: A snooped write miss (`snp_cmd`=2) from another requester to a held block invalidates it. `flush_valid` rises with the word only if the line was exclusive.
- R8: Snooped transactions whose `snp_id` equals the controller's own ID are ignored.
- R9: A miss to an address that maps to an exclusive line with a different tag first drives `bus_cmd`=3 (write back) with the old address and word. The read or write miss follows in the next cycle. A shared victim is replaced without a write back. Line index is the low address bits.
- R10: No bus command is issued and no line changes on behalf of the processor until `bus_gnt` is high. `bus_req` stays high while waiting.
- R11: A snoop that hits the target line while the request waits for the grant is applied first. At the grant the request is judged again, so an exclusive victim that was invalidated meanwhile is not written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request pending; held with its fields until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, kept high while `bus_req` stays high |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write back |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_data | output | DATA_W | Data of a write back or write miss |
| bus_id | output | ID_W | Requester ID of this controller |
| fill_valid | input | 1 | Memory reply to this controller's read miss |
| fill_data | input | DATA_W | Reply data |
| snp_cmd | input | 2 | Observed bus command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Observed address |
| snp_id | input | ID_W | Requester of the observed command |
| flush_valid | output | 1 | Dirty word supplied for the observed command |
| flush_data | output | DATA_W | The flushed word |

## Verification
A wrong line state shows up at the ports on the next access to that line. A line wrongly kept valid answers a later read with no bus command. A line wrongly kept exclusive skips the write miss, or omits the flush when snooped. A lost dirty bit removes a write back that should come one cycle before the miss. The directed tests move each line through every state. After each move they probe it with a read, a write or a remote snoop, so a stale state is caught within one access. The grant is withheld for several cycles while snoops are injected, which exposes early state changes and a failure to judge the request again.

// File: rtl/snoop_cache_ctl.sv
module snoop_cache_ctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int ID_W   = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic [ID_W-1:0]   bus_id,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_id,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] L_INV = 2'd0, L_SHR = 2'd1, L_EXC = 2'd2;

  typedef enum logic [2:0] {IDLE, ARB, EVICT, MISS, FILL} phase_t;

  phase_t           ph;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic [1:0]        st_q  [LINES];

  wire [IDX_W-1:0] cidx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] ctag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] sidx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] stag = snp_addr[ADDR_W-1:IDX_W];

  wire snp_hit = (snp_cmd == C_RD || snp_cmd == C_WR) && snp_id != MY_ID &&
                 st_q[sidx] != L_INV && tag_q[sidx] == stag;
  wire tag_eq  = tag_q[cidx] == ctag;
  wire perm    = tag_eq && (cpu_write ? st_q[cidx] == L_EXC : st_q[cidx] != L_INV);
  wire hit_ok  = perm && !(snp_hit && sidx == cidx);
  wire dirty_victim = st_q[cidx] == L_EXC && !tag_eq;

  assign flush_valid = snp_hit && st_q[sidx] == L_EXC;
  assign flush_data  = dat_q[sidx];

  assign cpu_ready = (ph == IDLE && cpu_valid && hit_ok) ||
                     (ph == MISS && cpu_write) ||
                     (ph == FILL && fill_valid);
  assign cpu_rdata = (ph == FILL) ? fill_data : dat_q[cidx];

  assign bus_req  = ph != IDLE;
  assign bus_id   = MY_ID;
  assign bus_cmd  = (ph == EVICT) ? C_WB :
                    (ph == MISS)  ? (cpu_write ? C_WR : C_RD) : C_NONE;
  assign bus_addr = (ph == EVICT) ? {tag_q[cidx], cidx} : cpu_addr;
  assign bus_data = (ph == EVICT) ? dat_q[cidx] : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= IDLE;
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= L_INV;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (snp_hit)
        st_q[sidx] <= (snp_cmd == C_RD) ? L_SHR : L_INV;
      case (ph)
        IDLE: begin
          if (cpu_valid && hit_ok && cpu_write) dat_q[cidx] <= cpu_wdata;
          else if (cpu_valid && !perm) ph <= ARB;
        end
        ARB:   if (bus_gnt) ph <= dirty_victim ? EVICT : MISS;
        EVICT: begin
          st_q[cidx] <= L_INV;
          ph <= MISS;
        end
        MISS: begin
          if (cpu_write) begin
            tag_q[cidx] <= ctag;
            dat_q[cidx] <= cpu_wdata;
            st_q[cidx]  <= L_EXC;
            ph <= IDLE;
          end else begin
            ph <= FILL;
          end
        end
        FILL: begin
          if (fill_valid) begin
            tag_q[cidx] <= ctag;
            dat_q[cidx] <= fill_data;
            st_q[cidx]  <= L_SHR;
            ph <= IDLE;
          end
        end
        default: ph <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_cache_ctl_chk.sv
module snoop_cache_ctl_chk #(
  parameter int ID_W = 2,
  parameter logic [ID_W-1:0] MY_ID = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic            cpu_ready,
  input logic            bus_req,
  input logic            bus_gnt,
  input logic [1:0]      bus_cmd,
  input logic [1:0]      snp_cmd,
  input logic [ID_W-1:0] snp_id,
  input logic            flush_valid
);
  a_r10_cmd_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd != 2'd0 |-> bus_gnt && bus_req);
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  a_r9_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd == 2'd3 |=> bus_cmd == 2'd1 || bus_cmd == 2'd2);
  a_r8_no_self_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> snp_id != MY_ID);
  a_r6_flush_on_miss_only: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> snp_cmd == 2'd1 || snp_cmd == 2'd2);
  a_r1_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);
endmodule

bind snoop_cache_ctl snoop_cache_ctl_chk #(.ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .snp_cmd(snp_cmd),
  .snp_id(snp_id), .flush_valid(flush_valid)
);

// File: tb/snoop_cache_ctl_test.sv
module snoop_cache_ctl_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cpu_valid = 0, cpu_write = 0;
  logic [7:0] cpu_addr = 0;
  logic [15:0] cpu_wdata = 0, cpu_rdata, bus_data, fill_data, flush_data;
  logic cpu_ready, bus_req, bus_gnt, fill_valid, flush_valid;
  logic [1:0] bus_cmd, snp_cmd = 0, bus_id, snp_id = 0;
  logic [7:0] bus_addr, snp_addr = 0;
  logic gnt_en = 1;

  assign bus_gnt = bus_req & gnt_en;

  snoop_cache_ctl uut (.*);

  logic [15:0] mem [256];
  int n_rd = 0, n_wr = 0, n_wb = 0, n_tx = 0;
  logic [1:0] prev_cmd = 0, last_cmd = 0;
  logic [7:0] wb_addr = 0;
  logic [15:0] wb_data = 0;

  always @(posedge clk) begin
    fill_valid <= (bus_cmd == 2'd1);
    fill_data  <= mem[bus_addr];
    if (bus_cmd != 2'd0) begin
      n_tx <= n_tx + 1;
      prev_cmd <= last_cmd;
      last_cmd <= bus_cmd;
    end
    if (bus_cmd == 2'd1) n_rd <= n_rd + 1;
    if (bus_cmd == 2'd2) n_wr <= n_wr + 1;
    if (bus_cmd == 2'd3) begin
      n_wb <= n_wb + 1;
      wb_addr <= bus_addr;
      wb_data <= bus_data;
      mem[bus_addr] <= bus_data;
    end
    if (flush_valid) mem[snp_addr] <= flush_data;
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic cpu_access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                            output logic [15:0] rd);
    int t = 0;
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    rd = 'x;
    forever begin
      #1;
      if (cpu_ready) begin
        rd = cpu_rdata;
        @(negedge clk);
        cpu_valid = 0;
        break;
      end
      @(negedge clk);
      if (++t > 60) begin
        chk(0, "handshake timeout", t, 60);
        cpu_valid = 0;
        break;
      end
    end
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] a, input logic [1:0] id,
                       output bit fv, output logic [15:0] fd);
    snp_cmd = cmd; snp_addr = a; snp_id = id;
    #1;
    fv = flush_valid; fd = flush_data;
    @(negedge clk);
    snp_cmd = 0;
  endtask

  logic [15:0] rd;
  bit fv;
  logic [15:0] fd;
  int t0, r0, w0, b0;

  task automatic t_reset();
    chk(bus_req == 0 && cpu_ready == 0 && bus_cmd == 0 && flush_valid == 0, "R1 idle outputs",
        {bus_req, cpu_ready, bus_cmd, flush_valid}, 0);
    snoop(2'd2, 8'h10, 2'd1, fv, fd);
    chk(fv == 0, "R1 no line valid after reset", fv, 0);
  endtask

  task automatic t_read();
    r0 = n_rd;
    cpu_access(0, 8'h10, 0, rd);
    chk(rd == 16'h1111 && n_rd == r0 + 1, "R1 R2 read miss fills", rd, 16'h1111);
    t0 = n_tx;
    cpu_access(0, 8'h10, 0, rd);
    chk(rd == 16'h1111 && n_tx == t0, "R3 read hit no traffic", n_tx - t0, 0);
  endtask

  task automatic t_write();
    w0 = n_wr;
    cpu_access(1, 8'h10, 16'hAAAA, rd);
    chk(n_wr == w0 + 1, "R4 write on shared issues write miss", n_wr - w0, 1);
    t0 = n_tx;
    cpu_access(1, 8'h10, 16'hBBBB, rd);
    cpu_access(0, 8'h10, 0, rd);
    chk(rd == 16'hBBBB && n_tx == t0, "R5 exclusive write hit silent", rd, 16'hBBBB);
  endtask

  task automatic t_snoop_rd();
    snoop(2'd1, 8'h10, 2'd1, fv, fd);
    chk(fv && fd == 16'hBBBB, "R6 flush on remote read", fd, 16'hBBBB);
    t0 = n_tx; w0 = n_wr;
    cpu_access(0, 8'h10, 0, rd);
    chk(rd == 16'hBBBB && n_tx == t0, "R6 line still readable", rd, 16'hBBBB);
    cpu_access(1, 8'h10, 16'hCCCC, rd);
    chk(n_wr == w0 + 1, "R6 line became shared", n_wr - w0, 1);
  endtask

  task automatic t_snoop_wr();
    snoop(2'd2, 8'h10, 2'd3, fv, fd);
    chk(fv && fd == 16'hCCCC, "R7 flush on remote write of exclusive", fd, 16'hCCCC);
    r0 = n_rd;
    cpu_access(0, 8'h10, 0, rd);
    chk(n_rd == r0 + 1 && rd == 16'hCCCC, "R7 line invalidated", n_rd - r0, 1);
    snoop(2'd2, 8'h10, 2'd1, fv, fd);
    chk(fv == 0, "R7 no flush for shared", fv, 0);
    cpu_access(0, 8'h10, 0, rd);
    chk(n_rd == r0 + 2, "R7 shared line invalidated", n_rd - r0, 2);
  endtask

  task automatic t_own_id();
    snoop(2'd2, 8'h10, 2'd0, fv, fd);
    t0 = n_tx;
    cpu_access(0, 8'h10, 0, rd);
    chk(fv == 0 && n_tx == t0, "R8 own transaction ignored", n_tx - t0, 0);
  endtask

  task automatic t_evict();
    cpu_access(1, 8'h10, 16'hDDDD, rd);
    b0 = n_wb;
    cpu_access(0, 8'h20, 0, rd);
    chk(n_wb == b0 + 1 && wb_addr == 8'h10 && wb_data == 16'hDDDD, "R9 read eviction write back",
        wb_data, 16'hDDDD);
    chk(prev_cmd == 2'd3 && last_cmd == 2'd1 && rd == 16'h2222, "R9 write back before read miss",
        {prev_cmd, last_cmd}, 4'hD);
    cpu_access(1, 8'h20, 16'hEEEE, rd);
    cpu_access(1, 8'h30, 16'hFFFF, rd);
    chk(prev_cmd == 2'd3 && last_cmd == 2'd2 && wb_addr == 8'h20 && wb_data == 16'hEEEE,
        "R9 write eviction write back", wb_data, 16'hEEEE);
    cpu_access(0, 8'h11, 0, rd);
    b0 = n_wb;
    cpu_access(0, 8'h21, 0, rd);
    chk(n_wb == b0, "R9 shared victim dropped silently", n_wb - b0, 0);
  endtask

  task automatic t_grant_wait();
    gnt_en = 0; t0 = n_tx;
    fork
      cpu_access(0, 8'h05, 0, rd);
      begin
        repeat (4) @(negedge clk);
        chk(bus_req == 1 && n_tx == t0 && cpu_ready == 0, "R10 nothing before grant",
            n_tx - t0, 0);
        gnt_en = 1;
      end
    join
    chk(rd == 16'h5555, "R10 read after grant", rd, 16'h5555);
  endtask

  task automatic t_restart();
    gnt_en = 0; b0 = n_wb; r0 = n_rd;
    fork
      cpu_access(0, 8'h40, 0, rd);
      begin
        repeat (2) @(negedge clk);
        snoop(2'd2, 8'h30, 2'd2, fv, fd);
        chk(fv && fd == 16'hFFFF, "R11 snoop served while waiting", fd, 16'hFFFF);
        @(negedge clk);
        gnt_en = 1;
      end
    join
    chk(n_wb == b0 && n_rd == r0 + 1 && rd == 16'h4444, "R11 request re-evaluated",
        n_wb - b0, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[8'h10] = 16'h1111; mem[8'h20] = 16'h2222;
    mem[8'h05] = 16'h5555; mem[8'h40] = 16'h4444;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_snoop_rd();
    t_snoop_wr();
    t_own_id();
    t_evict();
    t_grant_wait();
    t_restart();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end
endmodule